// File: doc/BRIEF.md
# Scan Chain Configuration Router

This block routes a serial boundary-scan path. Data from the backplane test input passes first through a short internal register and then through up to three local scan ports before it reaches the backplane test output. An 8-bit mode register decides which ports are chained. Ports that are selected always come in ascending order. Each one is followed by a single synchronizing pad flop, so the data it returns is retimed to the scan clock before it moves on.

Two conditions bypass every port and leave only the internal register between input and output. One is a loopback bit in the mode register. The other is the parked state, which comes in as an input from the surrounding tap logic. A clock-stop bit lets the local test clocks halt while the ports are parked, so that idle parts of a system draw less power. A stopped clock is held low and is gated glitch-free. The top bit of the mode register is a read-only status bit that reports a counter-at-zero condition supplied from outside.

Top module: `scan_route_top`

## Requirements
- R1: A synchronous active-high reset sets the mode register readback to 8'h01. This means port 1 is enabled, loopback is off, the clock-stop bit is clear and the status bit is 0.
- R2: A write (mode_we high at a clock edge) updates readback bits 4:0 from mode_wdata[4:0]. Bits 6:5 always read 0, whatever was written to them.
- R3: Readback bit 7 equals the ctr_zero input as sampled at the previous clock edge. Writes have no effect on bit 7.
- R4: When the ports are unparked and bit 4 is 0, mode bits 0, 1 and 2 insert local ports 1, 2 and 3. The inserted ports follow the internal register in ascending order. With zero-delay ports, the input-to-output latency is REG_LEN plus one cycle for each inserted port.
- R5: Each inserted port n receives the preceding stage on lsp_tdo[n-1]. The value it returns on lsp_tdi[n-1] is captured in that port's pad flop at the rising clock edge. A port that is not inserted has lsp_tdo held at 1, and its lsp_tdi has no effect on tdo.
- R6: When mode bit 4 is 1, the path is the internal register alone (latency REG_LEN), and every lsp_tdo is held at 1.
- R7: While parked is high, the path is the internal register alone, and every lsp_tdo is held at 1.
- R8: While parked is high and mode bit 3 is 1, every lsp_tck stays low. The gating enable changes only while clk is low.
- R9: While parked is low, or while mode bit 3 is 0, every lsp_tck follows clk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset (tap logic reset state) |
| tdi | input | 1 | Backplane serial data in |
| tdo | output | 1 | Backplane serial data out |
| parked | input | 1 | High while the local ports are parked |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| ctr_zero | input | 1 | Counter enabled and at zero |
| mode_q | output | 8 | Mode register readback |
| lsp_tdo | output | N_LSP | Serial data to each local port |
| lsp_tdi | input | N_LSP | Serial data returned by each local port |
| lsp_tck | output | N_LSP | Gated test clock for each local port |

## Verification
The bench models local port 2 as an inverter and ports 1 and 3 as plain wires, and measures the end-to-end shift latency. A port skipped by mistake, a missing pad flop, or ports chained in the wrong order each show up as a latency off by one or as a missing inversion. Loopback is tested with every port-enable bit set, and the parked state is tested the same way. A design that let either condition fall through to the port selection would add cycles and invert data. The clock tests count local clock edges in three cases: stop bit set while parked, stop bit clear while parked, and stop bit set while unparked. A design that gated on the stop bit alone would lose clocks in the unparked case. The tests also write all ones to the mode register to catch reserved or status bits that latch the write data.

// File: rtl/scan_route_pkg.sv
package scan_route_pkg;
  localparam int MODE_W    = 8;
  localparam int N_LSP     = 3;
  localparam int STOP_BIT  = 3;
  localparam int LOOP_BIT  = 4;
  localparam int STAT_BIT  = 7;
  localparam int CFG_W     = LOOP_BIT + 1;
  localparam int RSV_W     = STAT_BIT - LOOP_BIT - 1;
  localparam logic [CFG_W-1:0] CFG_RESET = 5'b00001;
endpackage

// File: rtl/scan_mode_reg.sv
module scan_mode_reg
  import scan_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [MODE_W-1:0] wdata,
  input  logic              ctr_zero,
  output logic [MODE_W-1:0] mode_q
);
  logic [CFG_W-1:0] cfg_q;
  logic             stat_q;
  logic             unused_wbits;

  assign unused_wbits = ^wdata[MODE_W-1:CFG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
    end else if (we) begin
      cfg_q <= wdata[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= 1'b0;
    else     stat_q <= ctr_zero;
  end

  assign mode_q = {stat_q, {RSV_W{1'b0}}, cfg_q};
endmodule

// File: rtl/scan_chain_path.sv
module scan_chain_path #(
  parameter int REG_LEN = 4,
  parameter int N_PORT  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tdi,
  input  logic [N_PORT-1:0] sel,
  input  logic [N_PORT-1:0] lsp_tdi,
  output logic [N_PORT-1:0] lsp_tdo,
  output logic              tdo
);
  logic [REG_LEN-1:0] ireg_q;
  logic [N_PORT-1:0]  pad_q;
  logic [N_PORT:0]    node;

  // internal register path ahead of all ports
  always_ff @(posedge clk) begin
    if (rst) begin
      ireg_q <= '0;
    end else begin
      ireg_q[0] <= tdi;
      for (int k = 1; k < REG_LEN; k++) ireg_q[k] <= ireg_q[k-1];
    end
  end

  assign node[0] = ireg_q[REG_LEN-1];

  for (genvar g = 0; g < N_PORT; g++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) pad_q[g] <= 1'b0;
      else     pad_q[g] <= lsp_tdi[g];
    end
    assign lsp_tdo[g]  = sel[g] ? node[g]  : 1'b1;
    assign node[g+1]   = sel[g] ? pad_q[g] : node[g];
  end

  assign tdo = node[N_PORT];
endmodule

// File: rtl/scan_tck_gate.sv
module scan_tck_gate (
  input  logic clk,
  input  logic rst,
  input  logic stop,
  output logic tck
);
  logic run_q;

  // enable moves only while clk is low, so the AND cannot glitch
  always_ff @(negedge clk) begin
    if (rst) run_q <= 1'b1;
    else     run_q <= ~stop;
  end

  assign tck = clk & run_q;
endmodule

// File: rtl/scan_route_top.sv
module scan_route_top
  import scan_route_pkg::*;
#(
  parameter int REG_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tdi,
  output logic              tdo,
  input  logic              parked,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              ctr_zero,
  output logic [MODE_W-1:0] mode_q,
  output logic [N_LSP-1:0]  lsp_tdo,
  input  logic [N_LSP-1:0]  lsp_tdi,
  output logic [N_LSP-1:0]  lsp_tck
);
  logic [N_LSP-1:0] sel;
  logic             bypass;
  logic             stop;

  scan_mode_reg u_mode (
    .clk      (clk),
    .rst      (rst),
    .we       (mode_we),
    .wdata    (mode_wdata),
    .ctr_zero (ctr_zero),
    .mode_q   (mode_q)
  );

  assign bypass = parked | mode_q[LOOP_BIT];
  assign sel    = bypass ? '0 : mode_q[N_LSP-1:0];
  assign stop   = parked & mode_q[STOP_BIT];

  scan_chain_path #(.REG_LEN(REG_LEN), .N_PORT(N_LSP)) u_path (
    .clk     (clk),
    .rst     (rst),
    .tdi     (tdi),
    .sel     (sel),
    .lsp_tdi (lsp_tdi),
    .lsp_tdo (lsp_tdo),
    .tdo     (tdo)
  );

  for (genvar g = 0; g < N_LSP; g++) begin : g_gate
    scan_tck_gate u_gate (
      .clk  (clk),
      .rst  (rst),
      .stop (stop),
      .tck  (lsp_tck[g])
    );
  end
endmodule

// File: rtl/scan_route_chk.sv
module scan_route_chk
  import scan_route_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              parked,
  input logic              mode_we,
  input logic [MODE_W-1:0] mode_wdata,
  input logic              ctr_zero,
  input logic [MODE_W-1:0] mode_q,
  input logic [N_LSP-1:0]  lsp_tdo
);
  // R1
  rst_val_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> mode_q == 8'h01);

  // R2
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q[STAT_BIT-1:CFG_W] == '0);

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
    mode_we |=> mode_q[CFG_W-1:0] == $past(mode_wdata[CFG_W-1:0]));

  // R3
  stat_track_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> mode_q[STAT_BIT] == $past(ctr_zero));

  // R6
  loop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q[LOOP_BIT] |-> lsp_tdo == '1);

  // R7
  park_idle_chk: assert property (@(posedge clk) disable iff (rst)
    parked |-> lsp_tdo == '1);
endmodule

bind scan_route_top scan_route_chk u_chk (.*);

// File: tb/scan_route_top_tb.sv
module scan_route_top_tb;
  localparam int RL = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tdi = 1'b0;
  logic       tdo;
  logic       parked = 1'b0;
  logic       mode_we = 1'b0;
  logic [7:0] mode_wdata = 8'h00;
  logic       ctr_zero = 1'b0;
  logic [7:0] mode_q;
  logic [2:0] lsp_tdo, lsp_tdi, lsp_tck;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int tck_cnt [3] = '{0, 0, 0};

  always #5 clk = ~clk;

  // port 2 modeled as an inverter, ports 1 and 3 as wires
  assign lsp_tdi = lsp_tdo ^ 3'b010;

  always @(posedge lsp_tck[0]) tck_cnt[0]++;
  always @(posedge lsp_tck[1]) tck_cnt[1]++;
  always @(posedge lsp_tck[2]) tck_cnt[2]++;

  scan_route_top #(.REG_LEN(RL)) u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [7:0] d);
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = d;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset value", mode_q, 8'h01);
    write_mode(8'h17);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset after write", mode_q, 8'h01);
  endtask

  task automatic t_fields();
    write_mode(8'hFF);
    check("R2 R3 write all ones", mode_q, 8'h1F);
    ctr_zero = 1'b1;
    @(negedge clk);
    check("R3 status follows ctr_zero", mode_q[7], 1'b1);
    ctr_zero = 1'b0;
    @(negedge clk);
    check("R3 status clears", mode_q[7], 1'b0);
    write_mode(8'h60);
    check("R2 reserved read zero", mode_q, 8'h00);
  endtask

  task automatic t_path(input logic [7:0] m, input logic park, input string req);
    logic [2:0] s;
    logic [63:0] hist;
    logic [15:0] lf;
    int lat, err;
    s   = (park || m[4]) ? 3'b000 : m[2:0];
    lat = RL + $countones(s);
    err = 0;
    lf  = 16'hACE1 ^ {8'h00, m};
    write_mode(m);
    parked = park;
    for (int j = 0; j < 48; j++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      hist[j] = lf[0];
    end
    for (int j = 0; j < 48; j++) begin
      @(negedge clk);
      if (j >= lat && tdo !== (hist[j-lat] ^ s[1])) err++;
      for (int p = 0; p < 3; p++)
        if (!s[p] && lsp_tdo[p] !== 1'b1) err++;
      tdi = hist[j];
    end
    check(req, err, 0);
    parked = 1'b0;
  endtask

  task automatic t_clock(input logic [7:0] m, input logic park, input int exp, input string req);
    int c0 [3];
    int low_err;
    write_mode(m);
    parked = park;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 3; p++) c0[p] = tck_cnt[p];
    low_err = 0;
    repeat (10) begin
      @(posedge clk); #1;
      if (exp == 0 && lsp_tck !== 3'b000) low_err++;
    end
    @(negedge clk);
    for (int p = 0; p < 3; p++) check(req, tck_cnt[p] - c0[p], exp);
    check(req, low_err, 0);
    parked = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fields();
    t_path(8'h00, 1'b0, "R4 no ports");
    t_path(8'h01, 1'b0, "R4 R5 port1 only");
    t_path(8'h02, 1'b0, "R5 port2 only");
    t_path(8'h03, 1'b0, "R4 ports 1 2");
    t_path(8'h05, 1'b0, "R5 ports 1 3 skip 2");
    t_path(8'h06, 1'b0, "R4 ports 2 3");
    t_path(8'h07, 1'b0, "R4 all ports");
    t_path(8'h17, 1'b0, "R6 loopback override");
    t_path(8'h07, 1'b1, "R7 parked bypass");
    t_clock(8'h08, 1'b1, 0,  "R8 parked stop");
    t_clock(8'h00, 1'b1, 10, "R9 parked run");
    t_clock(8'h08, 1'b0, 10, "R9 unparked run");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule